// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the two low address bits for each beat of a four-beat burst in a synchronous burst memory. When a burst opens, a load strobe captures a starting beat address from the low bits of the external address bus, together with the order select. Each advance strobe then steps to the next beat. The beat addresses follow one of two orders. In linear order the address counts up and wraps. In interleaved order the start address is XOR'd with the beat index.

The order select is captured at load and held for the rest of the burst. Interleaved order is the safe default. The internal order register resets to interleaved, and the board should tie the select input high through a pull-up so that a floating pin also gives interleaved order. A last-beat flag marks the fourth beat. One more advance after that wraps the sequence back to the start address.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset is released, `beat_addr_o` is 00 and `last_o` is 0.
- R2: A cycle with `load_i` high makes `beat_addr_o` equal to the `start_i` value sampled at that edge, starting from the next cycle, with `last_o` at 0.
- R3: When `order_i` is 0 at load (linear order), beat k of the burst (k = 0..3) has address (start + k) mod 4.
- R4: When `order_i` is 1 at load (interleaved order), beat k of the burst has address start XOR k.
- R5: `last_o` is 1 exactly while the burst is on its fourth beat (k = 3).
- R6: An advance taken on the fourth beat returns `beat_addr_o` to the start address and clears `last_o`.
- R7: When `load_i` and `adv_i` are both high in one cycle, the load is performed and the advance is ignored.
- R8: A change of `order_i` between loads does not change the sequence of the burst in progress.
- R9: In a cycle with neither `load_i` nor `adv_i` high, `beat_addr_o` and `last_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Opens a burst: capture start address and order |
| adv_i | input | 1 | Step to the next beat |
| start_i | input | 2 | Starting beat address (low external address bits) |
| order_i | input | 1 | Order select: 0 linear, 1 interleaved (tie high by default) |
| beat_addr_o | output | 2 | Current beat address |
| last_o | output | 1 | High on the fourth beat of the burst |

## Verification
On every cycle the assertions check the load capture, the hold when the block is idle, and the clearing of the last-beat flag on wrap. They also check that each beat address matches a beat index and start address that the checker tracks itself, for whichever order was captured. Some properties only show up across a whole scenario: load winning over a simultaneous advance, a mid-burst order change having no effect, and the complete wrapped sequence for every start address in both orders. The bench sweeps these exhaustively.

// File: rtl/bas_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: nothing beyond the two order encodings used on order_i.
package bas_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bas_seed_reg.sv
// Module: bas_seed_reg
// Holds the start address and order of the current burst.
// Assumes: load has priority and is the only way to change the held values;
// reset selects start 0 and interleaved order.
module bas_seed_reg
    import bas_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] start_i,
    input  logic         order_i,
    output logic [W-1:0] start_q,
    output order_e       order_q
);
    // Capture the seed and order on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load_i) begin
            start_q <= start_i;
            order_q <= order_e'(order_i);
        end
    end
endmodule

// File: rtl/bas_beat_ctr.sv
// Module: bas_beat_ctr
// Counts the beat index of the burst, wrapping at 2**W beats.
// Assumes: load clears the index and takes priority over advance.
module bas_beat_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         adv_i,
    output logic [W-1:0] beat_q,
    output logic         last_o
);
    localparam logic [W-1:0] LAST_BEAT = {W{1'b1}};

    // Clear on load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_i) begin
            beat_q <= '0;
        end else if (adv_i) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // Flag the final beat of the burst.
    always_comb last_o = (beat_q == LAST_BEAT);
endmodule

// File: rtl/bas_order_map.sv
// Module: bas_order_map
// Maps start address and beat index to the beat address in the held order.
// Assumes: purely combinational, the inputs come from registers.
module bas_order_map
    import bas_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] beat_i,
    input  order_e       order_i,
    output logic [W-1:0] addr_o
);
    logic [W-1:0] lin_addr;
    logic [W-1:0] ilv_addr;

    // Per-bit XOR for interleaved order.
    for (genvar b = 0; b < W; b++) begin : g_ilv
        assign ilv_addr[b] = start_i[b] ^ beat_i[b];
    end

    // Modular sum for linear order.
    always_comb lin_addr = start_i + beat_i;

    // Select the held order.
    always_comb addr_o = (order_i == ORD_LINEAR) ? lin_addr : ilv_addr;
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Produces the beat address sequence of a wrapping burst in linear or
// interleaved order; the order is captured at load and held.
// Assumes: order_i is pulled high at the board so a floating pin means
// interleaved; synchronous active-low reset.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         adv_i,
    input  logic [W-1:0] start_i,
    input  logic         order_i,
    output logic [W-1:0] beat_addr_o,
    output logic         last_o
);
    logic [W-1:0] start_q;
    order_e       order_q;
    logic [W-1:0] beat_q;

    bas_seed_reg #(.W(W)) u_seed (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .order_i (order_i),
        .start_q (start_q),
        .order_q (order_q)
    );

    bas_beat_ctr #(.W(W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .adv_i  (adv_i),
        .beat_q (beat_q),
        .last_o (last_o)
    );

    bas_order_map #(.W(W)) u_map (
        .start_i (start_q),
        .beat_i  (beat_q),
        .order_i (order_q),
        .addr_o  (beat_addr_o)
    );
endmodule

// File: rtl/bas_checker.sv
// Module: bas_checker
// Cycle-by-cycle properties of burst_addr_seq, using its own tracking of the
// burst seed, order and beat index built from the ports.
module bas_checker #(
    parameter int W = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_i,
    input logic         adv_i,
    input logic [W-1:0] start_i,
    input logic         order_i,
    input logic [W-1:0] beat_addr_o,
    input logic         last_o
);
    logic [W-1:0] trk_start;
    logic [W-1:0] trk_beat;
    logic         trk_order;

    // Track the burst from the port-level strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_start <= '0;
            trk_beat  <= '0;
            trk_order <= 1'b1;
        end else if (load_i) begin
            trk_start <= start_i;
            trk_beat  <= '0;
            trk_order <= order_i;
        end else if (adv_i) begin
            trk_beat  <= trk_beat + 1'b1;
        end
    end

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_addr_o == $past(start_i)) && !last_o);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(beat_addr_o) && $stable(last_o));

    assert_wrap_clears_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && last_o) |=> !last_o && (beat_addr_o == trk_start));

    assert_linear_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_order |-> beat_addr_o == W'(trk_start + trk_beat));

    assert_interleave_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trk_order |-> beat_addr_o == (trk_start ^ trk_beat));

    assert_last_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o == (trk_beat == {W{1'b1}}));
endmodule

bind burst_addr_seq bas_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .adv_i       (adv_i),
    .start_i     (start_i),
    .order_i     (order_i),
    .beat_addr_o (beat_addr_o),
    .last_o      (last_o)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic       adv_i = 1'b0;
    logic [1:0] start_i = 2'b00;
    logic       order_i = 1'b1;
    logic [1:0] beat_addr_o;
    logic       last_o;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    burst_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
        .start_i(start_i), .order_i(order_i),
        .beat_addr_o(beat_addr_o), .last_o(last_o)
    );

    // Drive at the falling edge, then sample shortly after the next rising edge.
    task automatic step(input logic ld, input logic ad, input logic [1:0] st, input logic md);
        @(negedge clk);
        load_i = ld; adv_i = ad; start_i = st; order_i = md;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] ea, input logic el);
        n_chk++;
        if (beat_addr_o !== ea || last_o !== el) begin
            n_bad++;
            $display("FAIL %s: addr=%b last=%b expected addr=%b last=%b",
                     req, beat_addr_o, last_o, ea, el);
        end
    endtask

    function automatic logic [1:0] expect_addr(input logic [1:0] s, input int k, input logic md);
        return md ? (s ^ 2'(k)) : 2'((s + k) % 4);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(0, 0, 2'b00, 1'b1);
        step(0, 0, 2'b00, 1'b1);
        rst_n = 1'b1;
        step(0, 0, 2'b00, 1'b1);
        check("R1 reset", 2'b00, 1'b0);

        // Exhaustive sweep: every start, both orders, five advances (wrap).
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                step(1, 0, 2'(s), 1'(md));
                check("R2 load", 2'(s), 1'b0);
                for (int k = 1; k <= 5; k++) begin
                    step(0, 1, 2'(~s), 1'(md));
                    check(md ? "R4/R5/R6 interleave" : "R3/R5/R6 linear",
                          expect_addr(2'(s), k % 4, 1'(md)), (k % 4) == 3);
                end
            end
        end

        // R9: idle cycles hold the current beat.
        step(1, 0, 2'b10, 1'b0);
        step(0, 1, 2'b00, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 2'b01, 1'b1);
            check("R9 idle hold", 2'b11, 1'b0);
        end

        // R7: load and advance together -> load wins.
        step(0, 1, 2'b00, 1'b0);
        step(1, 1, 2'b01, 1'b1);
        check("R7 load priority", 2'b01, 1'b0);
        step(0, 1, 2'b00, 1'b0);
        check("R7 order from load", 2'b00, 1'b0);

        // R8: order input toggled mid-burst does not change the sequence.
        for (int md = 0; md < 2; md++) begin
            step(1, 0, 2'b11, 1'(md));
            for (int k = 1; k <= 4; k++) begin
                step(0, 1, 2'b00, 1'((md + k) % 2));
                check("R8 order held", expect_addr(2'b11, k % 4, 1'(md)), (k % 4) == 3);
            end
        end

        // R1: reset mid-burst returns to the reset state.
        step(1, 0, 2'b10, 1'b0);
        step(0, 1, 2'b00, 1'b0);
        rst_n = 1'b0;
        step(0, 0, 2'b00, 1'b1);
        rst_n = 1'b1;
        check("R1 reset mid-burst", 2'b00, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule